// File: doc/BRIEF.md
# Card Slot Detect and Status Register Block

This block is a small word-addressed register window that a processor uses to supervise a removable memory card slot. It returns two fixed identification words, a zero word for a flash-programming location that is not implemented, and a status word that reports the slot's write-protect switch and a card-insertion event.

The write-protect bit is a live level: it shows the current, synchronized state of the write-protect input. The insertion bit is sticky. A high level on the card-present input sets it and raises the interrupt output. The bit and the interrupt then stay set until software writes a one to that bit position of the status word. Both slot inputs are asynchronous to the bus clock and pass through a two-stage synchronizer before any logic uses them.

Reads are combinational from the word address. A write takes effect at the clock edge on which `bus_we` is high.

Top module: `card_slot_regs`

## Requirements
- R1: Reads of word 0 return 0x41034003, reads of word 1 return 0, and reads of word 3 return 0x00000011.
- R2: Bit 0 of status word 2 equals the write-protect input delayed by two clock edges through the synchronizer. A change of the input is visible after the second rising edge and not after the first.
- R3: A high card-present input sets bit 3 of word 2 and raises `card_irq` on the third rising edge after the input rises. The two signals always agree.
- R4: When the card-present input falls, bit 3 and `card_irq` stay set.
- R5: A write to word 2 whose data has bit 3 set clears bit 3 and `card_irq` at that edge. A write to word 2 with data bit 3 at zero leaves bit 3 unchanged.
- R6: If the synchronized card-present level is high on the edge of a clearing write, bit 3 and `card_irq` remain set.
- R7: Writes to words 1 and 3, and to any word other than 2, change no state and no read value. Every word other than 0 to 3 reads 0.
- R8: After reset, `card_irq` is 0 and word 2 reads 0. Bits 1, 2 and 4 to 31 of word 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wp_in | input | 1 | Write-protect switch level (asynchronous) |
| card_in | input | 1 | Card-present level (asynchronous) |
| card_irq | output | 1 | Card-insertion interrupt, high while the sticky bit is set |

## Verification
The set path of the insertion bit and the software clear path can act on the same clock edge. The bench holds the card-present input high long enough to fill the synchronizer and then issues a write of a one to bit 3 of word 2. It expects the bit and the interrupt to remain high, because a set takes priority over a clear. It then lowers the input, waits until the synchronizer has drained, and repeats the clear write, which must now drop both. The same pair is also checked edge by edge by a checker property that ties the sticky bit's next value to the synchronized level and the clear strobe.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t ID_WORD     = 32'h4103_4003;
  localparam word_t DECODE_WORD = 32'h0000_0011;

  localparam int IDX_ID     = 0;
  localparam int IDX_FLASH  = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_DECODE = 3;

  localparam int WP_BIT  = 0;
  localparam int INS_BIT = 3;

  function automatic word_t status_word(input logic wp, input logic ins);
    word_t w;
    w = '0;
    w[WP_BIT]  = wp;
    w[INS_BIT] = ins;
    return w;
  endfunction

  function automatic word_t read_word(input int unsigned idx, input word_t status);
    case (idx)
      IDX_ID:     return ID_WORD;
      IDX_STATUS: return status;
      IDX_DECODE: return DECODE_WORD;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/csr_sync.sv
module csr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/csr_insert_latch.sv
module csr_insert_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lvl,
  input  logic clr_hit,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_lvl) flag_q <= 1'b1;
    else if (clr_hit) flag_q <= 1'b0;
  end
endmodule

// File: rtl/csr_readmux.sv
module csr_readmux
  import csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_lvl,
  input  logic              ins_flag,
  output word_t             rdata
);
  always_comb begin
    rdata = read_word(int'(addr), status_word(wp_lvl, ins_flag));
  end
endmodule

// File: rtl/card_slot_regs.sv
module card_slot_regs
  import csr_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wp_in,
  input  logic              card_in,
  output logic              card_irq
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_lvl;
  logic              wp_sync;
  logic              ins_sync;
  logic              status_wr;
  logic              clr_hit;
  logic              ins_q;
  logic              unused_wdata;

  csr_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({card_in, wp_in}),
    .sync_out (sync_lvl)
  );

  assign wp_sync  = sync_lvl[0];
  assign ins_sync = sync_lvl[1];

  assign status_wr    = bus_we && (int'(bus_addr) == IDX_STATUS);
  assign clr_hit      = status_wr && bus_wdata[INS_BIT];
  assign unused_wdata = ^{bus_wdata[31:INS_BIT+1], bus_wdata[INS_BIT-1:0]};

  csr_insert_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_lvl (ins_sync),
    .clr_hit (clr_hit),
    .flag_q  (ins_q)
  );

  csr_readmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr     (bus_addr),
    .wp_lvl   (wp_sync),
    .ins_flag (ins_q),
    .rdata    (bus_rdata)
  );

  assign card_irq = ins_q;
endmodule

// File: rtl/card_slot_regs_chk.sv
module card_slot_regs_chk
  import csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              card_irq,
  input logic              wp_sync,
  input logic              ins_sync,
  input logic              clr_hit,
  input logic              ins_q
);
  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == IDX_ID) |-> (bus_rdata == ID_WORD)); // R1
  AST_WP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == IDX_STATUS) |-> (bus_rdata[WP_BIT] == wp_sync)); // R2
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == IDX_STATUS) |-> (bus_rdata[INS_BIT] == card_irq)); // R3
  AST_SET_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_sync |=> ins_q); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_q && !clr_hit) |=> ins_q); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !ins_sync) |=> !ins_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && ins_sync) |=> ins_q); // R6
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) > IDX_DECODE) |-> (bus_rdata == '0)); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_q) |-> $past(ins_sync)); // R8
endmodule

bind card_slot_regs card_slot_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .card_irq  (card_irq),
  .wp_sync   (wp_sync),
  .ins_sync  (ins_sync),
  .clr_hit   (clr_hit),
  .ins_q     (ins_q)
);

// File: tb/tb_card_slot_regs.sv
`timescale 1ns/1ps
module tb_card_slot_regs;
  localparam int ADDR_W = 6;
  localparam int NWORDS = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              wp_in = 1'b0;
  logic              card_in = 1'b0;
  logic              card_irq;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  card_slot_regs #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_in(wp_in),
    .card_in(card_in), .card_irq(card_irq)
  );

  // Expected read value, computed from the register map in the requirements.
  function automatic logic [31:0] expect_word(input int idx, input logic wp, input logic ins);
    logic [31:0] v;
    v = 32'd0;
    if (idx == 0) v = 32'h4103_4003;
    else if (idx == 3) v = 32'd17;
    else if (idx == 2) v = (ins ? 32'd8 : 32'd0) + (wp ? 32'd1 : 32'd0);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read(input int idx, output logic [31:0] v);
    bus_addr = idx[ADDR_W-1:0];
    #1;
    v = bus_rdata;
  endtask

  task automatic write(input int idx, input logic [31:0] d);
    bus_addr  = idx[ADDR_W-1:0];
    bus_wdata = d;
    bus_we    = 1'b1;
    edges(1);
    bus_we    = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk);
    read(2, v);
    check("R8 reset status", v, 32'd0);
    check("R8 reset irq", {31'd0, card_irq}, 32'd0);
    edges(2);
    rst_n = 1'b1;
    edges(1);

    for (int a = 0; a < NWORDS; a++) begin
      read(a, v);
      check($sformatf("R1/R7 read word %0d", a), v, expect_word(a, 1'b0, 1'b0));
    end

    wp_in = 1'b1;
    edges(1);
    read(2, v);
    check("R2 wp after one edge", v, 32'd0);
    edges(1);
    read(2, v);
    check("R2 wp after two edges", v, expect_word(2, 1'b1, 1'b0));
    wp_in = 1'b0;
    edges(2);
    read(2, v);
    check("R2 wp falls", v, 32'd0);

    card_in = 1'b1;
    edges(2);
    check("R3 irq not yet", {31'd0, card_irq}, 32'd0);
    edges(1);
    check("R3 irq raised", {31'd0, card_irq}, 32'd1);
    read(2, v);
    check("R3 status bit3", v, expect_word(2, 1'b0, 1'b1));
    card_in = 1'b0;
    edges(5);
    check("R4 sticky irq", {31'd0, card_irq}, 32'd1);

    wp_in = 1'b1;
    edges(2);
    for (int a = 0; a < NWORDS; a++) begin
      if (a == 2) continue;
      write(a, 32'hFFFF_FFFF);
      check($sformatf("R7 write word %0d irq", a), {31'd0, card_irq}, 32'd1);
      read(2, v);
      check($sformatf("R7 write word %0d status", a), v, expect_word(2, 1'b1, 1'b1));
      read(a, v);
      check($sformatf("R7 write word %0d readback", a), v, expect_word(a, 1'b1, 1'b1));
    end

    write(2, 32'hFFFF_FFF7);
    read(2, v);
    check("R5 write without bit3", v, expect_word(2, 1'b1, 1'b1));
    write(2, 32'h0000_0008);
    check("R5 clear irq", {31'd0, card_irq}, 32'd0);
    read(2, v);
    check("R5 clear status, wp kept", v, expect_word(2, 1'b1, 1'b0));

    card_in = 1'b1;
    edges(4);
    write(2, 32'h0000_0008);
    check("R6 set wins irq", {31'd0, card_irq}, 32'd1);
    read(2, v);
    check("R6 set wins status", v, expect_word(2, 1'b1, 1'b1));
    card_in = 1'b0;
    edges(3);
    write(2, 32'h0000_0008);
    check("R5 clear after drain", {31'd0, card_irq}, 32'd0);

    wp_in = 1'b0;
    edges(2);
    for (int a = 0; a < NWORDS; a++) begin
      read(a, v);
      check($sformatf("R8 final read word %0d", a), v, expect_word(a, 1'b0, 1'b0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule